// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block turns a physical address into the index of the DRAM row that holds it. Software programs eight boundary registers. Each register holds the end of its row in 64 MiB units and counts the rows below it, so each row starts where the row before it ends. A row whose boundary repeats the one before it holds no memory. A mode register supplies two things: whether the memory runs on one channel or two, and whether error correction is on. In two-channel mode only the lower half of the rows is in use.

An address is decoded when its valid strobe is raised. One clock later the block returns the row index and an out-of-range flag, together with a result-valid pulse. Three outputs follow the programmed state at all times: a bitmap of the rows that hold memory, the total memory size, and the two mode flags.

Top module: `dram_row_decoder`

## Requirements
- R1: A write with `cfg_addr` 0 to 7 loads that row's boundary from `cfg_wdata[6:0]`. Bit 7 and the bits above it are discarded.
- R2: A write with `cfg_addr` 8 loads the mode. `dual_channel` is `cfg_wdata[21]`. `ecc_enabled` is 1 only when `cfg_wdata[19:18]` is 2'b01.
- R3: `populated[i]` is 1 when row i is active and its boundary differs from row i-1's boundary. For row 0 the comparison is with zero. Eight rows are active in one-channel mode and rows 0 to 3 in two-channel mode.
- R4: `total_size` equals the boundary of the last active row: row 7 in one-channel mode, row 3 in two-channel mode.
- R5: A decode returns the lowest-index populated row whose boundary is greater than `addr[31:26]`. `addr[25:0]` does not affect the result.
- R6: When no populated row qualifies, the decode sets `out_of_range` and drives `row_idx` to 0. With non-decreasing boundaries this happens whenever `addr[31:26]` is at or above `total_size`.
- R7: `res_valid` is 1 in the cycle after each cycle in which `addr_valid` is 1, and 0 otherwise. `row_idx` and `out_of_range` hold their values between results.
- R8: In two-channel mode rows 4 to 7 are never selected and are reported as unpopulated, whatever their boundaries hold.
- R9: A decode strobed in the same cycle as a boundary write uses the boundaries held before that write.
- R10: After reset all boundaries and both mode flags are 0. `res_valid`, `row_idx` and `out_of_range` are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register select: 0-7 row boundaries, 8 mode |
| cfg_wdata | input | 32 | Register write data |
| addr_valid | input | 1 | Address strobe |
| addr | input | 32 | Physical address to decode |
| res_valid | output | 1 | Decode result valid, one cycle after the strobe |
| row_idx | output | 3 | Decoded row index |
| out_of_range | output | 1 | Address lies beyond the populated memory |
| populated | output | 8 | Bitmap of rows that hold memory |
| total_size | output | 7 | Total memory in 64 MiB units |
| dual_channel | output | 1 | Two-channel mode flag |
| ecc_enabled | output | 1 | Error-correction mode flag |

## Verification
A boundary write and an address decode can fall in the same clock cycle. The bench provokes this by lowering row 0's boundary from 2 to 1 while it strobes an address whose upper field is 1. The decode must return row 0, which follows from the old boundaries. The same address decoded one cycle later must return row 1, which follows from the new boundaries.

// File: rtl/dram_row_decoder.sv
module dram_row_decoder #(
  parameter int NUM_ROWS    = 8,
  parameter int BND_W       = 7,
  parameter int ADDR_W      = 32,
  parameter int GRAIN_SHIFT = 26,
  parameter int CFG_AW      = 4,
  parameter int CFG_DW      = 32,
  parameter int MODE_SEL    = 8,
  parameter int DUAL_BIT    = 21,
  parameter int INTEG_LSB   = 18
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [CFG_DW-1:0]           cfg_wdata,
  input  logic                        addr_valid,
  input  logic [ADDR_W-1:0]           addr,
  output logic                        res_valid,
  output logic [$clog2(NUM_ROWS)-1:0] row_idx,
  output logic                        out_of_range,
  output logic [NUM_ROWS-1:0]         populated,
  output logic [BND_W-1:0]            total_size,
  output logic                        dual_channel,
  output logic                        ecc_enabled
);
  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam int HALF  = NUM_ROWS / 2;
  localparam int HI_W  = ADDR_W - GRAIN_SHIFT;

  logic [BND_W-1:0] bnd [NUM_ROWS];
  logic             dual_q;
  logic [1:0]       integ_q;
  logic [BND_W-1:0] hi_ext;
  logic             found;
  logic [ROW_W-1:0] sel;

  wire unused_bits = ^{cfg_wdata, addr[GRAIN_SHIFT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ROWS; i++) bnd[i] <= '0;
      dual_q  <= 1'b0;
      integ_q <= 2'b00;
    end else if (cfg_we) begin
      if (cfg_addr < CFG_AW'(NUM_ROWS))
        bnd[cfg_addr[ROW_W-1:0]] <= cfg_wdata[BND_W-1:0];
      else if (cfg_addr == CFG_AW'(MODE_SEL)) begin
        dual_q  <= cfg_wdata[DUAL_BIT];
        integ_q <= cfg_wdata[INTEG_LSB +: 2];
      end
    end
  end

  assign dual_channel = dual_q;
  assign ecc_enabled  = (integ_q == 2'b01);
  assign total_size   = dual_q ? bnd[HALF-1] : bnd[NUM_ROWS-1];

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_pop
    if (g == 0) begin : g_first
      assign populated[g] = (bnd[g] != '0);
    end else if (g >= HALF) begin : g_upper
      assign populated[g] = !dual_q && (bnd[g] != bnd[g-1]);
    end else begin : g_lower
      assign populated[g] = (bnd[g] != bnd[g-1]);
    end
  end

  assign hi_ext = BND_W'(addr[ADDR_W-1 -: HI_W]);

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (populated[i] && (bnd[i] > hi_ext)) begin
        found = 1'b1;
        sel   = ROW_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      row_idx      <= '0;
      out_of_range <= 1'b0;
    end else begin
      res_valid <= addr_valid;
      if (addr_valid) begin
        row_idx      <= found ? sel : '0;
        out_of_range <= !found;
      end
    end
  end
endmodule

// File: rtl/dram_row_decoder_chk.sv
module dram_row_decoder_chk #(
  parameter int NUM_ROWS = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        addr_valid,
  input logic                        res_valid,
  input logic [$clog2(NUM_ROWS)-1:0] row_idx,
  input logic                        out_of_range,
  input logic [NUM_ROWS-1:0]         populated,
  input logic                        dual_channel
);
  localparam int HALF = NUM_ROWS / 2;

  logic [NUM_ROWS-1:0] pop_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pop_d <= '0;
    else        pop_d <= populated;

  AST_HIT_POPULATED: assert property (@(posedge clk) disable iff (!rst_n) res_valid && !out_of_range |-> pop_d[row_idx]); // R5
  AST_OOR_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) res_valid && out_of_range |-> row_idx == '0); // R6
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) addr_valid |=> res_valid); // R7
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !addr_valid |=> !res_valid); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !addr_valid |=> $stable(row_idx) && $stable(out_of_range)); // R7
  AST_DUAL_UPPER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) dual_channel |-> (populated >> HALF) == '0); // R8
  AST_DUAL_ROW_LOW: assert property (@(posedge clk) disable iff (!rst_n) res_valid && $past(dual_channel) |-> int'(row_idx) < HALF); // R8
endmodule

bind dram_row_decoder dram_row_decoder_chk #(.NUM_ROWS(NUM_ROWS)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .res_valid(res_valid),
  .row_idx(row_idx), .out_of_range(out_of_range), .populated(populated),
  .dual_channel(dual_channel)
);

// File: tb/dram_row_decoder_tb_top.sv
`timescale 1ns/1ps
module dram_row_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        addr_valid = 1'b0;
  logic [31:0] addr = '0;
  logic        res_valid, out_of_range, dual_channel, ecc_enabled;
  logic [2:0]  row_idx;
  logic [7:0]  populated;
  logic [6:0]  total_size;

  int n_checks = 0;
  int n_fail = 0;
  logic [6:0] m_bnd [8];
  logic       m_dual = 1'b0;

  always #2 clk = ~clk;

  dram_row_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .addr_valid(addr_valid), .addr(addr),
    .res_valid(res_valid), .row_idx(row_idx), .out_of_range(out_of_range),
    .populated(populated), .total_size(total_size),
    .dual_channel(dual_channel), .ecc_enabled(ecc_enabled)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pop();
    logic [7:0] p = '0;
    int act_rows = m_dual ? 4 : 8;
    for (int i = 0; i < act_rows; i++)
      p[i] = (m_bnd[i] != ((i == 0) ? 7'd0 : m_bnd[i-1]));
    return p;
  endfunction

  function automatic logic [6:0] exp_total();
    return m_dual ? m_bnd[3] : m_bnd[7];
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 8) m_bnd[a[2:0]] = d[6:0];
    else if (a == 8) m_dual = d[21];
  endtask

  task automatic decode(input logic [31:0] a);
    logic [7:0] p = exp_pop();
    logic [6:0] hi = {1'b0, a[31:26]};
    logic [2:0] er = '0;
    logic       eo = 1'b1;
    for (int i = 7; i >= 0; i--)
      if (p[i] && m_bnd[i] > hi) begin er = 3'(i); eo = 1'b0; end
    @(negedge clk);
    addr_valid = 1'b1; addr = a;
    @(negedge clk);
    addr_valid = 1'b0;
    check(res_valid === 1'b1, "R7 valid pulse", 32'(res_valid), 1);
    check(row_idx === er, eo ? "R6 row on miss" : (m_dual ? "R8 dual row" : "R5 row"), 32'(row_idx), 32'(er));
    check(out_of_range === eo, "R6 out_of_range", 32'(out_of_range), 32'(eo));
  endtask

  task automatic cfg_and_sweep(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7, input logic dual);
    logic [7:0] bs [8] = '{b0, b1, b2, b3, b4, b5, b6, b7};
    for (int i = 0; i < 8; i++) wr(4'(i), {24'h0, bs[i]});
    wr(4'd8, dual ? 32'h0020_0000 : 32'h0);
    check(populated === exp_pop(), m_dual ? "R8 bitmap" : "R3 bitmap", 32'(populated), 32'(exp_pop()));
    check(total_size === exp_total(), "R4 total", 32'(total_size), 32'(exp_total()));
    for (int h = 0; h < 64; h++)
      decode({6'(h), 26'(h * 1234567 + 99)});
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_checks++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_bnd[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(populated === 8'h0 && total_size === 7'h0, "R10 reset map", {populated, 1'b0, total_size}, 0);
    check(!res_valid && row_idx === 3'd0 && !out_of_range, "R10 reset result", {res_valid, row_idx, out_of_range}, 0);
    check(!dual_channel && !ecc_enabled, "R10 reset mode", {dual_channel, ecc_enabled}, 0);

    wr(4'd8, 32'h0004_0000);
    check(ecc_enabled === 1'b1, "R2 ecc on", 32'(ecc_enabled), 1);
    wr(4'd8, 32'h000C_0000);
    check(ecc_enabled === 1'b0, "R2 ecc other code", 32'(ecc_enabled), 0);
    wr(4'd8, 32'h0040_0000);
    check(dual_channel === 1'b0, "R2 channel 10", 32'(dual_channel), 0);
    wr(4'd8, 32'h0020_0000);
    check(dual_channel === 1'b1, "R2 dual", 32'(dual_channel), 1);

    cfg_and_sweep(8'd2, 8'd4, 8'd4, 8'd9, 8'd9, 8'd20, 8'd33, 8'hA8, 1'b0);
    check(total_size === 7'd40, "R1 reserved bit dropped", 32'(total_size), 40);
    check(populated === 8'b1110_1011, "R3 fixed bitmap", 32'(populated), 32'hEB);

    @(negedge clk);
    check(res_valid === 1'b0, "R7 single pulse", 32'(res_valid), 0);
    check(row_idx === 3'd0 && out_of_range === 1'b1, "R7 hold", {row_idx, out_of_range}, 1);

    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 32'd1;
    addr_valid = 1'b1; addr = {6'd1, 26'h3ABCDE};
    @(negedge clk);
    cfg_we = 1'b0; addr_valid = 1'b0;
    check(row_idx === 3'd0 && !out_of_range, "R9 old boundary used", {row_idx, out_of_range}, 0);
    m_bnd[0] = 7'd1;
    decode({6'd1, 26'h0});
    check(row_idx === 3'd1, "R9 new boundary next", 32'(row_idx), 1);

    cfg_and_sweep(8'd0, 8'd3, 8'd3, 8'd3, 8'd10, 8'd10, 8'd10, 8'd63, 1'b0);
    cfg_and_sweep(8'd5, 8'd5, 8'd12, 8'd16, 8'd30, 8'd40, 8'd50, 8'd60, 1'b1);
    check(populated === 8'b0000_1101, "R8 upper rows empty", 32'(populated), 32'h0D);
    check(total_size === 7'd16, "R4 dual total", 32'(total_size), 16);
    cfg_and_sweep(8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule